// File: doc/BRIEF.md
# Ownership Trace Message Generator

This block reports which software context owns the processor to a trace message queue. It produces an ownership message in two situations: software writes the process-ID value, or software writes the memory-mapped ownership register. The value from the last write is kept. When ownership has gone unreported for a long stretch, the block repeats that value in a forced message.

Every other trace message that enters the queue arrives as a strobe. The strobes advance a period counter. After a configurable number of them (255 by default) with no ownership message between, the block raises a periodic message. Messages leave through a single valid/ready slot. A stalled slot keeps its content, and a newer write overwrites the content.

Top module: `otm_gen`

## Requirements
- R1: A cycle with `pid_wr` high loads the message slot: `msg_valid` is 1 after the next rising edge, `msg_owner` equals `pid_data`, and `msg_periodic` is 0.
- R2: A cycle with `reg_wr` high and `pid_wr` low loads the slot in the same way, with `msg_owner` equal to `reg_wdata`.
- R3: A read (`reg_rd`) never creates a message. On the edge after the read, `reg_rdata` shows the latched owner value.
- R4: The latched owner value is always the data of the most recent accepted write from either source. Periodic messages carry this value.
- R5: Each cycle with `other_msg` high advances the period counter. The PERIOD-th strobe (255 by default) counted since the last ownership message loads a message with `msg_periodic` = 1.
- R6: Every ownership message clears the period counter, whether a write or an expiry caused it. A write also discards any strobe in the same cycle.
- R7: When a write and a counter expiry fall in the same cycle, exactly one message is produced. It carries the written value, with `msg_periodic` = 0.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, the slot holds its content. A new write replaces the held content with the new value.
- R9: After reset, `msg_valid` is 0, `reg_rdata` is 0, the latched owner is 0 and the counter is 0.
- R10: When `pid_wr` and `reg_wr` are both high in one cycle, the process-ID data is used for both the message and the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pid_wr | input | 1 | Process-ID register write strobe |
| pid_data | input | OWNER_W | Process-ID write data |
| reg_wr | input | 1 | Ownership register bus write strobe |
| reg_rd | input | 1 | Ownership register bus read strobe |
| reg_wdata | input | OWNER_W | Ownership register bus write data |
| reg_rdata | output | OWNER_W | Ownership register read data, registered |
| other_msg | input | 1 | Pulses once per other trace message queued |
| msg_valid | output | 1 | Ownership message available |
| msg_ready | input | 1 | Downstream queue accepts the message |
| msg_owner | output | OWNER_W | Owner value carried by the message |
| msg_periodic | output | 1 | 1 when the message was forced by the counter |

## Verification
Two moments are hard to hit from the ports: the cycle where the counter expires together with a write, and the cycle where it expires into an empty latch right after reset. Each needs exactly PERIOD-1 strobes with no message in between. The stimulus therefore counts strobes after a write and then places the write on the strobe that would cause expiry. In a separate run it resets and sends a full period of strobes before any write.

// File: rtl/otm_pkg.sv
package otm_pkg;
  typedef enum logic {
    SRC_WRITE    = 1'b0,
    SRC_PERIODIC = 1'b1
  } msg_src_e;
endpackage

// File: rtl/otm_owner_latch.sv
module otm_owner_latch #(
  parameter int OWNER_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pid_wr,
  input  logic [OWNER_W-1:0] pid_data,
  input  logic               reg_wr,
  input  logic [OWNER_W-1:0] reg_wdata,
  input  logic               reg_rd,
  output logic               wr_hit,
  output logic [OWNER_W-1:0] wr_value,
  output logic [OWNER_W-1:0] owner_q,
  output logic [OWNER_W-1:0] reg_rdata
);
  // process-ID write wins when both sources write together
  always_comb begin
    wr_hit   = pid_wr | reg_wr;
    wr_value = pid_wr ? pid_data : reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
    end else if (wr_hit) begin
      owner_q <= wr_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= owner_q;
    end
  end

  AST_LATCH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (pid_wr || reg_wr) |=> owner_q == $past(pid_wr ? pid_data : reg_wdata)) else $error("latch"); // R4
  AST_LATCH_STILL: assert property (@(posedge clk) disable iff (rst)
    (!pid_wr && !reg_wr) |=> $stable(owner_q)) else $error("latch hold"); // R4
endmodule

// File: rtl/otm_period_cnt.sv
module otm_period_cnt #(
  parameter int PERIOD = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic other_msg,
  input  logic clear,
  output logic expire
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;

  always_comb expire = other_msg && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clear || expire) begin
      cnt <= '0;
    end else if (other_msg) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST) else $error("cnt range"); // R5
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clear |=> cnt == '0) else $error("cnt clear"); // R6
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!clear && !other_msg) |=> $stable(cnt)) else $error("cnt idle"); // R5
endmodule

// File: rtl/otm_msg_slot.sv
module otm_msg_slot
  import otm_pkg::*;
#(
  parameter int OWNER_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [OWNER_W-1:0] load_owner,
  input  msg_src_e           load_src,
  input  logic               ready,
  output logic               valid,
  output logic [OWNER_W-1:0] owner,
  output logic               periodic
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      owner    <= '0;
      periodic <= 1'b0;
    end else if (load) begin
      valid    <= 1'b1;
      owner    <= load_owner;
      periodic <= (load_src == SRC_PERIODIC);
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready && !load) |=> valid && $stable(owner) && $stable(periodic)) else $error("hold"); // R8
  AST_SLOT_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (valid && ready && !load) |=> !valid) else $error("drain"); // R8
endmodule

// File: rtl/otm_gen.sv
module otm_gen
  import otm_pkg::*;
#(
  parameter int OWNER_W = 32,
  parameter int PERIOD  = 255
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pid_wr,
  input  logic [OWNER_W-1:0] pid_data,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [OWNER_W-1:0] reg_wdata,
  output logic [OWNER_W-1:0] reg_rdata,
  input  logic               other_msg,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [OWNER_W-1:0] msg_owner,
  output logic               msg_periodic
);
  logic               wr_hit;
  logic [OWNER_W-1:0] wr_value;
  logic [OWNER_W-1:0] owner_q;
  logic               expire;
  logic               new_req;
  logic [OWNER_W-1:0] req_owner;
  msg_src_e           req_src;

  otm_owner_latch #(.OWNER_W(OWNER_W)) u_latch (
    .clk(clk), .rst(rst),
    .pid_wr(pid_wr), .pid_data(pid_data),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .wr_hit(wr_hit), .wr_value(wr_value),
    .owner_q(owner_q), .reg_rdata(reg_rdata)
  );

  otm_period_cnt #(.PERIOD(PERIOD)) u_period (
    .clk(clk), .rst(rst),
    .other_msg(other_msg), .clear(wr_hit),
    .expire(expire)
  );

  // a write outranks a coincident expiry: one message, fresh value
  always_comb begin
    new_req   = wr_hit | expire;
    req_owner = wr_hit ? wr_value : owner_q;
    req_src   = wr_hit ? SRC_WRITE : SRC_PERIODIC;
  end

  otm_msg_slot #(.OWNER_W(OWNER_W)) u_slot (
    .clk(clk), .rst(rst),
    .load(new_req), .load_owner(req_owner), .load_src(req_src),
    .ready(msg_ready),
    .valid(msg_valid), .owner(msg_owner), .periodic(msg_periodic)
  );

  AST_WRITE_MSG: assert property (@(posedge clk) disable iff (rst)
    (pid_wr || reg_wr) |=> msg_valid && !msg_periodic) else $error("write msg"); // R1
  AST_PID_FIRST: assert property (@(posedge clk) disable iff (rst)
    pid_wr |=> msg_owner == $past(pid_data)) else $error("pid first"); // R10
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !pid_wr && !reg_wr && !expire && !msg_valid) |=> !msg_valid) else $error("read"); // R3
  AST_EXPIRE_MSG: assert property (@(posedge clk) disable iff (rst)
    (expire && !wr_hit) |=> msg_valid && msg_periodic) else $error("expire"); // R5
endmodule

// File: tb/sim_otm_gen.sv
module sim_otm_gen;
  localparam int W = 32;
  localparam int PERIOD = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pid_wr = 0, reg_wr = 0, reg_rd = 0, other_msg = 0, msg_ready = 1;
  logic [W-1:0] pid_data = '0, reg_wdata = '0;
  logic [W-1:0] reg_rdata, msg_owner;
  logic msg_valid, msg_periodic;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  otm_gen #(.OWNER_W(W), .PERIOD(PERIOD)) u0 (
    .clk(clk), .rst(rst), .pid_wr(pid_wr), .pid_data(pid_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .other_msg(other_msg), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_owner(msg_owner), .msg_periodic(msg_periodic)
  );

  typedef struct packed {
    logic pw; logic rw; logic rd; logic rdy;
    logic [W-1:0] dat;
    logic ev;
    logic [W-1:0] eo;
  } vec_t;

  // pw rw rd rdy data | expected valid, owner
  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_00A1, 1'b1, 32'h0000_00A1}, // R1
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0,         1'b0, 32'h0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_00B2, 1'b1, 32'h0000_00B2}, // R2
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_00C3, 1'b1, 32'h0000_00C3}, // R8 replace
    '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 32'h0000_00C3}, // R8 hold
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0,         1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 32'h0,         1'b0, 32'h0},         // R3
    '{1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_00D4, 1'b1, 32'h0000_00D4}, // R2
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h0,         1'b0, 32'h0}
  };

  task automatic check(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic others(input int n);
    other_msg = 1'b1;
    for (int i = 0; i < n; i++) tick();
    other_msg = 1'b0;
  endtask

  task automatic drain();
    msg_ready = 1'b1; tick();
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    check(msg_valid == 1'b0, "R9 valid after reset", W'(msg_valid), 0);
    check(reg_rdata == '0, "R9 rdata after reset", reg_rdata, 0);

    for (int v = 0; v < 9; v++) begin
      pid_wr = VECS[v].pw; reg_wr = VECS[v].rw; reg_rd = VECS[v].rd;
      msg_ready = VECS[v].rdy; pid_data = VECS[v].dat; reg_wdata = VECS[v].dat;
      tick();
      pid_wr = 0; reg_wr = 0; reg_rd = 0;
      check(msg_valid == VECS[v].ev, $sformatf("vector %0d valid (R1 R2 R3 R8)", v), W'(msg_valid), W'(VECS[v].ev));
      if (VECS[v].ev)
        check(msg_owner == VECS[v].eo, $sformatf("vector %0d owner (R1 R2 R8)", v), msg_owner, VECS[v].eo);
    end

    // R3: read returns latched value and raises nothing
    reg_rd = 1'b1; tick(); reg_rd = 1'b0;
    check(reg_rdata == 32'hD4, "R3 read data", reg_rdata, 32'hD4);
    check(msg_valid == 1'b0, "R3 no message on read", W'(msg_valid), 0);

    // R5 R4: periodic message after PERIOD strobes
    pid_data = 32'hE5; pid_wr = 1'b1; tick(); pid_wr = 1'b0;
    drain();
    others(PERIOD - 1);
    check(msg_valid == 1'b0, "R5 no message before period", W'(msg_valid), 0);
    others(1);
    check(msg_valid && msg_periodic, "R5 periodic message", W'({msg_valid, msg_periodic}), 3);
    check(msg_owner == 32'hE5, "R4 periodic owner", msg_owner, 32'hE5);
    drain();

    // R6: periodic cleared counter; a full period again is needed
    others(PERIOD - 1);
    check(msg_valid == 1'b0, "R6 counter cleared by periodic", W'(msg_valid), 0);
    reg_wdata = 32'hF6; reg_wr = 1'b1; tick(); reg_wr = 1'b0;
    drain();
    others(PERIOD - 1);
    check(msg_valid == 1'b0, "R6 counter cleared by write", W'(msg_valid), 0);
    others(1);
    check(msg_valid && msg_owner == 32'hF6, "R6 expiry after clear", msg_owner, 32'hF6);
    drain();

    // R7: write coincides with expiry
    others(PERIOD - 1);
    pid_data = 32'h77; pid_wr = 1'b1; other_msg = 1'b1; tick();
    pid_wr = 1'b0; other_msg = 1'b0;
    check(msg_valid && !msg_periodic, "R7 one write-kind message", W'({msg_valid, msg_periodic}), 2);
    check(msg_owner == 32'h77, "R7 new value", msg_owner, 32'h77);
    drain();
    check(msg_valid == 1'b0, "R7 only one message", W'(msg_valid), 0);

    // R10: both writes together
    pid_data = 32'h88; reg_wdata = 32'h99; pid_wr = 1'b1; reg_wr = 1'b1; tick();
    pid_wr = 1'b0; reg_wr = 1'b0;
    check(msg_owner == 32'h88, "R10 pid wins message", msg_owner, 32'h88);
    drain();
    reg_rd = 1'b1; tick(); reg_rd = 1'b0;
    check(reg_rdata == 32'h88, "R10 pid wins latch", reg_rdata, 32'h88);

    // R9: reset while pending, then periodic carries zero
    msg_ready = 1'b0; pid_data = 32'hAA; pid_wr = 1'b1; tick(); pid_wr = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0; msg_ready = 1'b1;
    check(msg_valid == 1'b0, "R9 reset drops pending", W'(msg_valid), 0);
    others(PERIOD);
    check(msg_valid && msg_owner == '0, "R9 latched owner zero", msg_owner, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule